// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the status and control register of a two-lane SIMD execution unit that handles both integer and floating-point work. Software reads and writes it as one 32-bit word. Each instruction that completes presents an update: its per-lane status results (overflow, underflow, guard, sticky, integer overflow) and the class of each lane's two source operands. From those classes the block works out the invalid-operation and divide-by-zero flags itself.

The register holds the rounding-mode control, which it drives to the datapath at all times, and four exception enables. It also holds a sticky integer-overflow summary per lane and one bit that belongs to software alone. When an update carries an error flag whose class is enabled, the block tells the datapath in the same cycle to drop the destination write. One cycle later it pulses a data-exception request. The error flags are recorded either way.

Top module: `fpu_status_ctl`

## Requirements
- R1: A synchronous reset clears every stored bit. After reset `sw_rdata` reads zero (the mode bit reads `MODE_VALUE`, default 0), `exc_req` is 0 and `rnd_mode` is 00.
- R2: Bits [1:0] hold the rounding mode (00 nearest, 01 toward zero, 10 toward +infinity, 11 toward -infinity). `rnd_mode` always equals the stored field.
- R3: A software write stores `sw_wdata` into the writable bits: 0-5, 7 and 9-24. Bit 6 is reserved, bits 25-31 are unused, and both always read 0. Bit 8 is the read-only mode bit. A software write takes priority over an update in the same cycle for every bit.
- R4: An update with no software write replaces lane L's flags, where L=0 is the low lane and L=1 the high lane. The flags sit at base 9+8*L: overflow +0, underflow +1, divide-by-zero +2, invalid +3, sticky +4, guard +5, integer overflow +6.
- R5: Operand classes are 3 bits each: 0 finite non-zero, 1 zero, 2 denormal, 3 infinity, 4 NaN, 5-7 finite non-zero. Operand A of lane L sits at `upd_cls_a[3L+2:3L]` and operand B at `upd_cls_b[3L+2:3L]`. A lane's invalid flag is set when either operand is denormal, infinity or NaN, or when `upd_div` is 1 and both operands are zero.
- R6: A lane's divide-by-zero flag is set only when `upd_div` is 1, operand B (the divisor) is zero and operand A (the dividend) is finite non-zero.
- R7: The summary bit of lane L (base +7) is set by an update whose integer-overflow flag for that lane is 1. It stays set until a software write clears it. A software write of the integer-overflow bit alone does not set it.
- R8: Bit 7 is a software-only overflow sticky. Updates never change it.
- R9: Bits 2, 3, 4 and 5 enable overflow, underflow, divide-by-zero and invalid. An update raises `exc_req` for one cycle, in the cycle after the update, when any enabled class is flagged in either lane. The enables used are the ones stored before that edge.
- R10: `rslt_commit` is `upd_valid` with the exception condition removed. A trapped update still records its flags. Its guard and sticky bits are unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Register read value |
| upd_valid | input | 1 | Instruction update strobe |
| upd_div | input | 1 | Update comes from a divide |
| upd_cls_a | input | 6 | Operand A class, 3 bits per lane |
| upd_cls_b | input | 6 | Operand B class, 3 bits per lane |
| upd_ovf | input | 2 | Overflow per lane |
| upd_unf | input | 2 | Underflow per lane |
| upd_grd | input | 2 | Guard bit per lane |
| upd_stk | input | 2 | Sticky bit per lane |
| upd_iov | input | 2 | Integer overflow per lane |
| rnd_mode | output | 2 | Current rounding mode |
| exc_req | output | 1 | Data-exception request pulse |
| rslt_commit | output | 1 | Destination write allowed |

## Verification
Random vectors mix software writes, updates and same-cycle collisions. The operand classes are drawn so that zero, denormal, infinity and NaN come up often. This separates the invalid path from the divide-by-zero path, and both from the plain status flags. Random enable patterns show whether the exception request follows the enabled classes and the stored enables rather than the raw flags. Directed cases cover the zero-by-zero divide against the non-zero-by-zero divide and against a non-divide, the summary bit against a software write of the overflow bit, the rounding encodings, and a write colliding with an update.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
   typedef enum logic [2:0] {
      CLS_NORM   = 3'd0,
      CLS_ZERO   = 3'd1,
      CLS_DENORM = 3'd2,
      CLS_INF    = 3'd3,
      CLS_NAN    = 3'd4
   } opnd_cls_e;

   localparam int LANES       = 2;
   localparam int RM_POS      = 0;
   localparam int EN_OVF_POS  = 2;
   localparam int EN_UNF_POS  = 3;
   localparam int EN_DBZ_POS  = 4;
   localparam int EN_INV_POS  = 5;
   localparam int RSVD_POS    = 6;
   localparam int SWSTK_POS   = 7;
   localparam int MODE_POS    = 8;
   localparam int LANE_BASE   = 9;
   localparam int LANE_STRIDE = 8;
   localparam int OFS_OVF     = 0;
   localparam int OFS_UNF     = 1;
   localparam int OFS_DBZ     = 2;
   localparam int OFS_INV     = 3;
   localparam int OFS_STK     = 4;
   localparam int OFS_GRD     = 5;
   localparam int OFS_IOV     = 6;
   localparam int OFS_SOV     = 7;
   localparam int USED_BITS   = LANE_BASE + LANES * LANE_STRIDE;

   typedef struct packed {
      logic ovf;
      logic unf;
      logic dbz;
      logic inv;
      logic stk;
      logic grd;
      logic iov;
   } lane_flags_t;

   // Bits software may write; the high summary bit is absent when merged.
   function automatic logic [63:0] wr_mask(input bit hi_summary);
      logic [63:0] m;
      m = '0;
      for (int b = RM_POS; b <= EN_INV_POS; b++) m[b] = 1'b1;
      m[SWSTK_POS] = 1'b1;
      for (int l = 0; l < LANES; l++)
         for (int o = 0; o < LANE_STRIDE; o++)
            m[LANE_BASE + l * LANE_STRIDE + o] = 1'b1;
      if (!hi_summary)
         for (int l = 1; l < LANES; l++)
            m[LANE_BASE + l * LANE_STRIDE + OFS_SOV] = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/fpsc_classify.sv
module fpsc_classify
   import fpsc_pkg::*;
#(
   parameter int CLS_W = 3
) (
   input  logic [CLS_W-1:0] cls_a,
   input  logic [CLS_W-1:0] cls_b,
   input  logic             is_div,
   output logic             inv,
   output logic             dbz
);
   localparam logic [CLS_W-1:0] K_ZERO = CLS_W'(CLS_ZERO);
   localparam logic [CLS_W-1:0] K_DEN  = CLS_W'(CLS_DENORM);
   localparam logic [CLS_W-1:0] K_INF  = CLS_W'(CLS_INF);
   localparam logic [CLS_W-1:0] K_NAN  = CLS_W'(CLS_NAN);

   logic a_zero, b_zero, a_bad, b_bad, a_finite_nz;

   always_comb begin
      a_zero      = (cls_a == K_ZERO);
      b_zero      = (cls_b == K_ZERO);
      a_bad       = (cls_a == K_DEN) || (cls_a == K_INF) || (cls_a == K_NAN);
      b_bad       = (cls_b == K_DEN) || (cls_b == K_INF) || (cls_b == K_NAN);
      a_finite_nz = !a_zero && !a_bad;
      inv         = a_bad || b_bad || (is_div && a_zero && b_zero);
      dbz         = is_div && b_zero && a_finite_nz;
   end
endmodule

// File: rtl/fpsc_trap.sv
module fpsc_trap #(
   parameter int LANES = 2
) (
   input  logic             valid,
   input  logic             en_ovf,
   input  logic             en_unf,
   input  logic             en_dbz,
   input  logic             en_inv,
   input  logic [LANES-1:0] ovf,
   input  logic [LANES-1:0] unf,
   input  logic [LANES-1:0] dbz,
   input  logic [LANES-1:0] inv,
   output logic             trap
);
   logic [3:0] hit;

   always_comb begin
      hit[0] = en_ovf && (|ovf);
      hit[1] = en_unf && (|unf);
      hit[2] = en_dbz && (|dbz);
      hit[3] = en_inv && (|inv);
      trap   = valid && (|hit);
   end
endmodule

// File: rtl/fpsc_regfile.sv
module fpsc_regfile
   import fpsc_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter bit HI_SUMMARY = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   sw_we,
   input  logic [REG_W-1:0]       sw_wdata,
   input  logic                   upd_valid,
   input  lane_flags_t [LANES-1:0] lane_new,
   output logic [REG_W-1:0]       q
);
   localparam logic [REG_W-1:0] WMASK = REG_W'(wr_mask(HI_SUMMARY));

   logic [LANES-1:0] iov_vec;
   logic [LANES-1:0] sov_set;
   logic [REG_W-1:0] nxt;

   for (genvar l = 0; l < LANES; l++) begin : g_iov
      assign iov_vec[l] = lane_new[l].iov;
   end

   if (HI_SUMMARY) begin : g_split_sov
      assign sov_set = iov_vec;
   end else begin : g_merged_sov
      assign sov_set = {{(LANES-1){1'b0}}, |iov_vec};
   end

   always_comb begin
      nxt = q;
      if (upd_valid) begin
         for (int l = 0; l < LANES; l++) begin
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_OVF] = lane_new[l].ovf;
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_UNF] = lane_new[l].unf;
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_DBZ] = lane_new[l].dbz;
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_INV] = lane_new[l].inv;
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_STK] = lane_new[l].stk;
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_GRD] = lane_new[l].grd;
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_IOV] = lane_new[l].iov;
            nxt[LANE_BASE + l*LANE_STRIDE + OFS_SOV] =
               q[LANE_BASE + l*LANE_STRIDE + OFS_SOV] | sov_set[l];
         end
      end
      if (sw_we) nxt = sw_wdata & WMASK;
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end
endmodule

// File: rtl/fpu_status_ctl.sv
module fpu_status_ctl
   import fpsc_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter int CLS_W      = 3,
   parameter bit MODE_VALUE = 1'b0,
   parameter bit HI_SUMMARY = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   sw_we,
   input  logic [REG_W-1:0]       sw_wdata,
   output logic [REG_W-1:0]       sw_rdata,
   input  logic                   upd_valid,
   input  logic                   upd_div,
   input  logic [LANES*CLS_W-1:0] upd_cls_a,
   input  logic [LANES*CLS_W-1:0] upd_cls_b,
   input  logic [LANES-1:0]       upd_ovf,
   input  logic [LANES-1:0]       upd_unf,
   input  logic [LANES-1:0]       upd_grd,
   input  logic [LANES-1:0]       upd_stk,
   input  logic [LANES-1:0]       upd_iov,
   output logic [1:0]             rnd_mode,
   output logic                   exc_req,
   output logic                   rslt_commit
);
   if (REG_W < USED_BITS || REG_W > 64) begin : g_bad_width
      $error("fpu_status_ctl: REG_W must lie between USED_BITS and 64");
   end
   if (CLS_W < 3) begin : g_bad_cls
      $error("fpu_status_ctl: CLS_W must be at least 3");
   end

   logic [REG_W-1:0]        q;
   logic [LANES-1:0]        inv_l, dbz_l;
   lane_flags_t [LANES-1:0] lane_new;
   logic                    trap;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      fpsc_classify #(.CLS_W(CLS_W)) u_cls (
         .cls_a  (upd_cls_a[l*CLS_W +: CLS_W]),
         .cls_b  (upd_cls_b[l*CLS_W +: CLS_W]),
         .is_div (upd_div),
         .inv    (inv_l[l]),
         .dbz    (dbz_l[l])
      );
      assign lane_new[l].ovf = upd_ovf[l];
      assign lane_new[l].unf = upd_unf[l];
      assign lane_new[l].dbz = dbz_l[l];
      assign lane_new[l].inv = inv_l[l];
      assign lane_new[l].stk = upd_stk[l];
      assign lane_new[l].grd = upd_grd[l];
      assign lane_new[l].iov = upd_iov[l];
   end

   fpsc_regfile #(.REG_W(REG_W), .HI_SUMMARY(HI_SUMMARY)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .sw_we     (sw_we),
      .sw_wdata  (sw_wdata),
      .upd_valid (upd_valid),
      .lane_new  (lane_new),
      .q         (q)
   );

   fpsc_trap #(.LANES(LANES)) u_trap (
      .valid  (upd_valid),
      .en_ovf (q[EN_OVF_POS]),
      .en_unf (q[EN_UNF_POS]),
      .en_dbz (q[EN_DBZ_POS]),
      .en_inv (q[EN_INV_POS]),
      .ovf    (upd_ovf),
      .unf    (upd_unf),
      .dbz    (dbz_l),
      .inv    (inv_l),
      .trap   (trap)
   );

   always_ff @(posedge clk) begin
      if (rst) exc_req <= 1'b0;
      else     exc_req <= trap;
   end

   assign rslt_commit = upd_valid && !trap;
   assign rnd_mode    = q[RM_POS +: 2];
   assign sw_rdata    = q | (REG_W'(MODE_VALUE) << MODE_POS);
endmodule

// File: rtl/fpsc_chk.sv
module fpsc_chk #(
   parameter int REG_W      = 32,
   parameter bit MODE_VALUE = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             sw_we,
   input logic [REG_W-1:0] sw_wdata,
   input logic [REG_W-1:0] sw_rdata,
   input logic             upd_valid,
   input logic [1:0]       upd_ovf,
   input logic [1:0]       upd_iov,
   input logic [1:0]       rnd_mode,
   input logic             exc_req,
   input logic             rslt_commit
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (sw_rdata == (REG_W'(MODE_VALUE) << 8)) && !exc_req);

   // R2
   rnd_write_chk: assert property (@(posedge clk) disable iff (rst)
      sw_we |=> rnd_mode == $past(sw_wdata[1:0]));

   // R3
   fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
      !sw_rdata[6] && (sw_rdata[REG_W-1:25] == '0) && (sw_rdata[8] == MODE_VALUE));

   // R4
   lane0_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      upd_valid && !sw_we |=> sw_rdata[9] == $past(upd_ovf[0]));

   // R7
   summary_set_chk: assert property (@(posedge clk) disable iff (rst)
      upd_valid && !sw_we && upd_iov[0] |=> sw_rdata[16]);

   // R7
   summary_hold_chk: assert property (@(posedge clk) disable iff (rst)
      sw_rdata[16] && !sw_we |=> sw_rdata[16]);

   // R8
   sw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      !sw_we |=> $stable(sw_rdata[7]));

   // R9
   exc_source_chk: assert property (@(posedge clk) disable iff (rst)
      !upd_valid |=> !exc_req);

   // R10
   commit_block_chk: assert property (@(posedge clk) disable iff (rst)
      upd_valid && !rslt_commit |=> exc_req);
endmodule

bind fpu_status_ctl fpsc_chk #(.REG_W(REG_W), .MODE_VALUE(MODE_VALUE)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .sw_we       (sw_we),
   .sw_wdata    (sw_wdata),
   .sw_rdata    (sw_rdata),
   .upd_valid   (upd_valid),
   .upd_ovf     (upd_ovf),
   .upd_iov     (upd_iov),
   .rnd_mode    (rnd_mode),
   .exc_req     (exc_req),
   .rslt_commit (rslt_commit)
);

// File: tb/sim_fpu_status_ctl.sv
module sim_fpu_status_ctl;
   localparam int CLK_P = 10;
   localparam logic [31:0] WMASK = 32'h01FF_FEBF;
   localparam logic [31:0] GS_MASK = 32'h0060_6000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sw_we = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] sw_rdata;
   logic upd_valid = 1'b0, upd_div = 1'b0;
   logic [5:0] upd_cls_a = '0, upd_cls_b = '0;
   logic [1:0] upd_ovf = '0, upd_unf = '0, upd_grd = '0, upd_stk = '0, upd_iov = '0;
   logic [1:0] rnd_mode;
   logic exc_req, rslt_commit;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [31:0] exp_q = '0;

   always #(CLK_P/2) clk = ~clk;

   fpu_status_ctl u0 (
      .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
      .upd_valid(upd_valid), .upd_div(upd_div), .upd_cls_a(upd_cls_a), .upd_cls_b(upd_cls_b),
      .upd_ovf(upd_ovf), .upd_unf(upd_unf), .upd_grd(upd_grd), .upd_stk(upd_stk),
      .upd_iov(upd_iov), .rnd_mode(rnd_mode), .exc_req(exc_req), .rslt_commit(rslt_commit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit cls_bad(input logic [2:0] c);
      return (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
   endfunction

   function automatic bit lane_inv(input logic [2:0] a, input logic [2:0] b, input bit div);
      return cls_bad(a) || cls_bad(b) || (div && a == 3'd1 && b == 3'd1);
   endfunction

   function automatic bit lane_dbz(input logic [2:0] a, input logic [2:0] b, input bit div);
      return div && b == 3'd1 && a != 3'd1 && !cls_bad(a);
   endfunction

   // Apply the inputs already set at this negedge, check, advance one cycle.
   task automatic run_vec();
      logic [1:0] inv, dbz;
      logic [31:0] nxt, m;
      bit trap;
      #1;
      for (int l = 0; l < 2; l++) begin
         inv[l] = lane_inv(upd_cls_a[3*l +: 3], upd_cls_b[3*l +: 3], upd_div);
         dbz[l] = lane_dbz(upd_cls_a[3*l +: 3], upd_cls_b[3*l +: 3], upd_div);
      end
      trap = upd_valid && ((exp_q[2] && |upd_ovf) || (exp_q[3] && |upd_unf) ||
                           (exp_q[4] && |dbz) || (exp_q[5] && |inv));
      chk("R10 commit", {31'd0, rslt_commit}, {31'd0, upd_valid && !trap});
      nxt = exp_q;
      if (upd_valid) begin
         for (int l = 0; l < 2; l++) begin
            nxt[9+8*l+0] = upd_ovf[l];
            nxt[9+8*l+1] = upd_unf[l];
            nxt[9+8*l+2] = dbz[l];
            nxt[9+8*l+3] = inv[l];
            nxt[9+8*l+4] = upd_stk[l];
            nxt[9+8*l+5] = upd_grd[l];
            nxt[9+8*l+6] = upd_iov[l];
            nxt[9+8*l+7] = exp_q[9+8*l+7] | upd_iov[l];
         end
      end
      if (sw_we) nxt = sw_wdata & WMASK;
      m = (trap && !sw_we) ? ~GS_MASK : 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R4 register", sw_rdata & m, nxt & m);
      chk("R9 exc_req", {31'd0, exc_req}, {31'd0, trap});
      chk("R2 rnd_mode", {30'd0, rnd_mode}, {30'd0, nxt[1:0]});
      exp_q = (nxt & m) | (sw_rdata & ~m);
   endtask

   task automatic drive(input bit we, input logic [31:0] wd, input bit v, input bit div,
                        input logic [5:0] ca, input logic [5:0] cb, input logic [1:0] ovf,
                        input logic [1:0] unf, input logic [1:0] iov);
      sw_we = we; sw_wdata = wd; upd_valid = v; upd_div = div;
      upd_cls_a = ca; upd_cls_b = cb; upd_ovf = ovf; upd_unf = unf;
      upd_grd = 2'b00; upd_stk = 2'b00; upd_iov = iov;
      run_vec();
   endtask

   function automatic logic [2:0] rnd_cls();
      int unsigned r = $urandom % 8;
      return (r < 3) ? 3'd0 : 3'(r - 2);
   endfunction

   initial begin
      void'($urandom(32'h5EED_0C1A));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", sw_rdata, 32'h0);
      chk("R1 exc_req", {31'd0, exc_req}, 32'h0);
      chk("R1 rnd_mode", {30'd0, rnd_mode}, 32'h0);
      rst = 1'b0;

      // R3 all-ones write
      drive(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
      chk("R3 write mask", sw_rdata, 32'h01FF_FEBF);
      drive(1, 32'h0, 0, 0, 0, 0, 0, 0, 0);
      chk("R7 cleared by write", {31'd0, sw_rdata[16]}, 32'h0);
      // R7 software write of integer overflow does not set summary
      drive(1, 32'h0000_8000, 0, 0, 0, 0, 0, 0, 0);
      chk("R7 sw iov no summary", {30'd0, sw_rdata[16:15]}, 32'h1);
      drive(0, 0, 1, 0, 0, 0, 0, 0, 2'b01);
      chk("R7 summary set", {31'd0, sw_rdata[16]}, 32'h1);
      drive(0, 0, 1, 0, 0, 0, 0, 0, 2'b00);
      chk("R7 summary held", {30'd0, sw_rdata[16:15]}, 32'h2);
      // R8 software-only sticky
      drive(1, 32'h0000_0080, 0, 0, 0, 0, 0, 0, 0);
      drive(0, 0, 1, 1, 6'o44, 6'o31, 2'b11, 2'b11, 2'b11);
      chk("R8 sw sticky kept", {31'd0, sw_rdata[7]}, 32'h1);
      // R5 zero/zero divide is invalid, not divide-by-zero; NaN in lane 1
      drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
      drive(0, 0, 1, 1, 6'o41, 6'o01, 0, 0, 0);
      chk("R5 lane0 inv,dbz", {30'd0, sw_rdata[12:11]}, 32'h2);
      chk("R5 lane1 nan inv", {31'd0, sw_rdata[20]}, 32'h1);
      // R6 non-zero / zero divide
      drive(0, 0, 1, 1, 6'o00, 6'o01, 0, 0, 0);
      chk("R6 dbz set", {30'd0, sw_rdata[12:11]}, 32'h1);
      drive(0, 0, 1, 0, 6'o00, 6'o01, 0, 0, 0);
      chk("R6 no divide", {30'd0, sw_rdata[12:11]}, 32'h0);
      // R9/R10 invalid enabled, high lane infinity
      drive(1, 32'h0000_0020, 0, 0, 0, 0, 0, 0, 0);
      sw_we = 0; upd_valid = 1; upd_div = 0; upd_cls_a = 6'o30; upd_cls_b = 0;
      upd_ovf = 0; upd_unf = 0; upd_iov = 0;
      #1 chk("R10 commit blocked", {31'd0, rslt_commit}, 32'h0);
      run_vec();
      chk("R9 exc raised", {31'd0, exc_req}, 32'h1);
      chk("R10 flag recorded", {31'd0, sw_rdata[20]}, 32'h1);
      drive(0, 0, 1, 0, 0, 0, 2'b10, 0, 0);
      chk("R9 disabled class", {31'd0, exc_req}, 32'h0);
      // R2 every rounding encoding
      for (int k = 0; k < 4; k++) begin
         drive(1, 32'(k), 0, 0, 0, 0, 0, 0, 0);
         chk("R2 mode", {30'd0, rnd_mode}, 32'(k));
      end
      // R3 write beats same-cycle update
      drive(1, 32'h0, 1, 0, 0, 0, 2'b11, 0, 2'b11);
      chk("R3 write priority", {29'd0, sw_rdata[16:15], sw_rdata[9]}, 32'h0);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [5:0] ca, cb;
         ca = {rnd_cls(), rnd_cls()};
         cb = {rnd_cls(), rnd_cls()};
         sw_we = ($urandom % 8) == 0;
         sw_wdata = $urandom;
         upd_valid = ($urandom % 4) != 0;
         upd_div = $urandom % 2;
         upd_cls_a = ca; upd_cls_b = cb;
         upd_ovf = {($urandom % 5) == 0, ($urandom % 5) == 0};
         upd_unf = {($urandom % 5) == 0, ($urandom % 5) == 0};
         upd_grd = 2'($urandom);
         upd_stk = 2'($urandom);
         upd_iov = {($urandom % 6) == 0, ($urandom % 6) == 0};
         run_vec();
      end

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule